// File: doc/BRIEF.md
# Vertical Field Countdown Divider

This block sets vertical timing by counting horizontal lines. It takes a line strobe and a separated vertical sync strobe. It decides whether each sync pulse starts a new field, and it issues a one-cycle retrace strobe at each field start. While the block has no lock, it accepts sync over a wide range of line positions. If no sync arrives, it runs on its own with fields of half a standard frame: 312 and 313 lines, alternating, for the 50 Hz standard, or 262 and 263 lines for the 60 Hz standard.

When a long enough run of sync pulses falls close to a standard field length, the block locks and sets its 50/60 Hz flag. While locked, it accepts only a narrow window around the nominal field length. If a pulse is missing, the field ends at the window's far edge (flywheel retrace). A run of such missing pulses sends the block back to search. With the default settings the line strobe runs at twice the line rate, and a prescaler turns every second strobe into one counted line. The block also reports field parity and the length of the field that just ended.

Top module: `field_countdown`

## Requirements
- R1: After reset, `locked`, `mode60`, `oddField`, `retraceStb`, `lineCount` and `fieldLines` are all 0.
- R2: With DOUBLE_RATE=1, `lineCount` rises by one on every second `lineStb`, counted from the last retrace. The first strobe after a retrace leaves it unchanged.
- R3: When unlocked, a `vsyncStb` seen while `lineCount` is in 244..361 causes a retrace. On the next cycle, `retraceStb` is 1, `fieldLines` holds the count at the sync, and `lineCount` is 0. A sync at any other count is ignored.
- R4: When unlocked and no sync is accepted, a retrace occurs when `lineCount` reaches the nominal length plus `oddField`. The nominal length is 312 with `mode60`=0 and 262 with `mode60`=1. `oddField` toggles on every retrace, so free-running fields alternate between the two lengths.
- R5: The block locks after 16 successive accepted syncs, each at a count within ±1 of the same nominal length (311..313 or 261..263). `locked` is set, and `mode60` is set to 1 for the 60 Hz standard or 0 for the 50 Hz standard.
- R6: Any field that breaks the run restarts it. This includes a field ended by a sync outside both narrow ranges, a free-running field, or a hit near the other standard. The lock then needs another full run of 16.
- R7: While locked, a sync is accepted only at a count of nominal−1..nominal+1. Syncs elsewhere are ignored.
- R8: While locked, a field with no accepted sync ends by retrace when `lineCount` reaches nominal+2. `fieldLines` then reads nominal+2.
- R9: After 6 successive flywheel retraces, `locked` clears. An accepted sync resets that run to zero.
- R10: `retraceStb` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStb | input | 1 | Line strobe, one cycle wide (twice per line when DOUBLE_RATE=1) |
| vsyncStb | input | 1 | Separated vertical sync strobe, one cycle wide |
| retraceStb | output | 1 | One-cycle start-of-retrace strobe |
| lineCount | output | CNT_W | Full lines counted since the last retrace |
| fieldLines | output | CNT_W | Length in lines of the field that just ended |
| locked | output | 1 | 1 = narrow window in use, 0 = search |
| mode60 | output | 1 | 1 = 60 Hz standard, 0 = 50 Hz standard |
| oddField | output | 1 | Field parity, toggles on every retrace |

## Verification
The bench builds the block with DOUBLE_RATE=1, a lock run of 16 and a miss limit of 6. These are the full-size values, so it does not use a scaled-down model.

Because every line takes two strobes, the bench reaches the prescaler phase after a retrace as well as the exact counter values at which the window edges sit. The full-size counts let it probe the off-by-one limits directly:
- a run of 15 that does not lock;
- a standard switch that restarts the run;
- five missing pulses followed by an accepted sync, which does not unlock;
- six missing pulses, which do.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic retrace;
  } ctlStb_t;
endpackage

// File: rtl/fcd_count.sv
module fcd_count
  import fcd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int DOUBLE_RATE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStb,
  input  ctlStb_t          ctl,
  output logic [CNT_W-1:0] lineCount,
  output logic [CNT_W-1:0] fieldLines,
  output logic             retraceStb
);
  logic lineTick;

  generate
    if (DOUBLE_RATE != 0) begin : g_pre
      logic halfSeen;
      always_ff @(posedge clk) begin
        if (!rstN || ctl.retrace) halfSeen <= 1'b0;
        else if (lineStb)          halfSeen <= ~halfSeen;
      end
      assign lineTick = lineStb & halfSeen;
    end else begin : g_direct
      assign lineTick = lineStb;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCount  <= '0;
      fieldLines <= '0;
      retraceStb <= 1'b0;
    end else begin
      retraceStb <= ctl.retrace;
      if (ctl.retrace) begin
        fieldLines <= lineCount;
        lineCount  <= '0;
      end else if (lineTick) begin
        lineCount <= lineCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int SEARCH_LO  = 244,
  parameter int SEARCH_HI  = 361,
  parameter int NOM50      = 312,
  parameter int NOM60      = 262,
  parameter int LOCK_HITS  = 16,
  parameter int MISS_LIMIT = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vsyncStb,
  input  logic [CNT_W-1:0] lineCount,
  output ctlStb_t          ctl,
  output logic             locked,
  output logic             mode60,
  output logic             oddField
);
  localparam int HIT_W  = $clog2(LOCK_HITS + 1);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] S_LO = CNT_W'(SEARCH_LO);
  localparam logic [CNT_W-1:0] S_HI = CNT_W'(SEARCH_HI);
  localparam logic [CNT_W-1:0] N50  = CNT_W'(NOM50);
  localparam logic [CNT_W-1:0] N60  = CNT_W'(NOM60);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [HIT_W-1:0] HIT_DONE   = HIT_W'(LOCK_HITS);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

  logic [HIT_W-1:0]  hitCnt, hitNext;
  logic [MISS_W-1:0] missCnt;
  logic              candStd;
  logic [CNT_W-1:0]  nom, winLo, winHi, freeLen;
  logic inSearch, inWin, near50, near60, syncOk, flyEnd, freeEnd;

  always_comb begin
    nom      = mode60 ? N60 : N50;
    winLo    = nom - ONE;
    winHi    = nom + ONE;
    freeLen  = nom + {{(CNT_W-1){1'b0}}, oddField};
    inSearch = (lineCount >= S_LO) && (lineCount <= S_HI);
    inWin    = (lineCount >= winLo) && (lineCount <= winHi);
    near50   = (lineCount >= N50 - ONE) && (lineCount <= N50 + ONE);
    near60   = (lineCount >= N60 - ONE) && (lineCount <= N60 + ONE);
    syncOk   = vsyncStb && (locked ? inWin : inSearch);
    flyEnd   = locked && (lineCount == winHi + ONE);
    freeEnd  = !locked && (lineCount == freeLen);
    ctl.retrace = syncOk || flyEnd || freeEnd;
    hitNext  = (hitCnt != '0 && candStd == near60) ? hitCnt + 1'b1 : HIT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locked   <= 1'b0;
      mode60   <= 1'b0;
      oddField <= 1'b0;
      candStd  <= 1'b0;
      hitCnt   <= '0;
      missCnt  <= '0;
    end else begin
      if (ctl.retrace) oddField <= ~oddField;
      if (!locked) begin
        if (syncOk && (near50 || near60)) begin
          candStd <= near60;
          if (hitNext == HIT_DONE) begin
            locked  <= 1'b1;
            mode60  <= near60;
            hitCnt  <= '0;
            missCnt <= '0;
          end else begin
            hitCnt <= hitNext;
          end
        end else if (ctl.retrace) begin
          hitCnt <= '0;
        end
      end else begin
        if (syncOk) begin
          missCnt <= '0;
        end else if (flyEnd) begin
          if (missCnt == MISS_LAST) begin
            locked  <= 1'b0;
            missCnt <= '0;
            hitCnt  <= '0;
          end else begin
            missCnt <= missCnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/field_countdown.sv
module field_countdown
  import fcd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int DOUBLE_RATE = 1,
  parameter int SEARCH_LO   = 244,
  parameter int SEARCH_HI   = 361,
  parameter int NOM50       = 312,
  parameter int NOM60       = 262,
  parameter int LOCK_HITS   = 16,
  parameter int MISS_LIMIT  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStb,
  input  logic             vsyncStb,
  output logic             retraceStb,
  output logic [CNT_W-1:0] lineCount,
  output logic [CNT_W-1:0] fieldLines,
  output logic             locked,
  output logic             mode60,
  output logic             oddField
);
  ctlStb_t ctl;

  fcd_ctrl #(
    .CNT_W(CNT_W), .SEARCH_LO(SEARCH_LO), .SEARCH_HI(SEARCH_HI),
    .NOM50(NOM50), .NOM60(NOM60), .LOCK_HITS(LOCK_HITS), .MISS_LIMIT(MISS_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .vsyncStb(vsyncStb), .lineCount(lineCount),
    .ctl(ctl), .locked(locked), .mode60(mode60), .oddField(oddField)
  );

  fcd_count #(.CNT_W(CNT_W), .DOUBLE_RATE(DOUBLE_RATE)) u_count (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .ctl(ctl),
    .lineCount(lineCount), .fieldLines(fieldLines), .retraceStb(retraceStb)
  );
endmodule

// File: rtl/fcd_check.sv
module fcd_check #(
  parameter int CNT_W     = 10,
  parameter int SEARCH_HI = 361,
  parameter int NOM50     = 312,
  parameter int NOM60     = 262
) (
  input logic             clk,
  input logic             rstN,
  input logic             vsyncStb,
  input logic             retraceStb,
  input logic [CNT_W-1:0] lineCount,
  input logic [CNT_W-1:0] fieldLines,
  input logic             locked,
  input logic             mode60
);
  int nomNow;
  assign nomNow = mode60 ? NOM60 : NOM50;

  // R3: the counter restarts together with the retrace strobe
  assert_count_cleared_R3: assert property (@(posedge clk) disable iff (!rstN)
    retraceStb |-> lineCount == '0);

  // R4: the count never runs past the search bound
  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(lineCount) <= SEARCH_HI);

  // R5: lock is gained only on a sync pulse
  assert_lock_on_sync_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(vsyncStb));

  // R8: a locked field is never shorter than the window or longer than its end
  assert_locked_field_R8: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked) && retraceStb) |->
      (int'(fieldLines) >= nomNow - 1 && int'(fieldLines) <= nomNow + 2));

  // R9: lock is lost only on a flywheel retrace
  assert_unlock_flywheel_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> (retraceStb && int'(fieldLines) == nomNow + 2));

  // R10: single-cycle retrace strobe
  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    retraceStb |=> !retraceStb);
endmodule

bind field_countdown fcd_check #(
  .CNT_W(CNT_W), .SEARCH_HI(SEARCH_HI), .NOM50(NOM50), .NOM60(NOM60)
) u_check (
  .clk(clk), .rstN(rstN), .vsyncStb(vsyncStb), .retraceStb(retraceStb),
  .lineCount(lineCount), .fieldLines(fieldLines), .locked(locked), .mode60(mode60)
);

// File: tb/field_countdown_test.sv
module field_countdown_test;
  localparam int CNT_W = 10;
  // {sync line or -1 for none, expected field length}, walked from a fresh search state
  localparam int NVEC = 5;
  localparam int VEC [NVEC][2] = '{'{300, 300}, '{244, 244}, '{243, 312}, '{-1, 313}, '{264, 264}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStb = 1'b0;
  logic vsyncStb = 1'b0;
  logic retraceStb, locked, mode60, oddField;
  logic [CNT_W-1:0] lineCount, fieldLines;

  int total = 0;
  int bad = 0;
  int fields = 0;
  logic gotRet;
  int fl;

  always #5 clk = ~clk;

  field_countdown #(
    .CNT_W(CNT_W), .DOUBLE_RATE(1), .SEARCH_LO(244), .SEARCH_HI(361),
    .NOM50(312), .NOM60(262), .LOCK_HITS(16), .MISS_LIMIT(6)
  ) uut (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .vsyncStb(vsyncStb),
    .retraceStb(retraceStb), .lineCount(lineCount), .fieldLines(fieldLines),
    .locked(locked), .mode60(mode60), .oddField(oddField)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    lineStb = 1'b1;
    @(negedge clk);
    if (retraceStb) gotRet = 1'b1;
    lineStb = 1'b0;
    @(negedge clk);
    if (retraceStb) gotRet = 1'b1;
  endtask

  task automatic line();
    strobe();
    strobe();
  endtask

  task automatic sync();
    vsyncStb = 1'b1;
    @(negedge clk);
    vsyncStb = 1'b0;
    if (retraceStb) gotRet = 1'b1;
  endtask

  // run lines until a retrace; pulse sync when the count equals syncAt
  task automatic runField(input int syncAt, output int len);
    gotRet = 1'b0;
    for (int i = 0; i < 400 && !gotRet; i++) begin
      line();
      if (!gotRet && syncAt >= 0 && int'(lineCount) == syncAt) sync();
    end
    if (gotRet) fields++;
    len = int'(fieldLines);
    chk(gotRet, "R3/R4 retrace seen", int'(gotRet), 1);
    chk(oddField == fields[0], "R4 parity", int'(oddField), fields % 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!locked && !mode60 && !oddField && !retraceStb, "R1 flags", int'({locked, mode60, oddField, retraceStb}), 0);
    chk(lineCount == '0 && fieldLines == '0, "R1 counts", int'(lineCount) + int'(fieldLines), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 prescaler: first strobe holds, second counts
    strobe();
    chk(lineCount == 10'd0, "R2 half strobe", int'(lineCount), 0);
    strobe();
    chk(lineCount == 10'd1, "R2 full line", int'(lineCount), 1);
    line();
    chk(lineCount == 10'd2, "R2 second line", int'(lineCount), 2);

    // table walk in search mode
    for (int v = 0; v < NVEC; v++) begin
      runField(VEC[v][0], fl);
      chk(fl == VEC[v][1], "R3/R4 field length", fl, VEC[v][1]);
      chk(lineCount == '0 && retraceStb, "R3 count cleared", int'(lineCount), 0);
      @(negedge clk);
      chk(!retraceStb, "R10 single strobe", int'(retraceStb), 0);
      chk(!locked, "R3 still search", int'(locked), 0);
    end

    // R6: standard switch restarts the run
    repeat (10) runField(262, fl);
    runField(312, fl);
    repeat (15) runField(262, fl);
    chk(!locked, "R6 switch restarts run", int'(locked), 0);
    // R6 free field also restarts; R4 free length in 50 Hz mode
    exp = 312 + (fields % 2);
    runField(-1, fl);
    chk(fl == exp, "R4 free length 50", fl, exp);
    repeat (15) runField(261, fl);
    chk(!locked, "R6 fifteen hits do not lock", int'(locked), 0);
    runField(261, fl);
    chk(locked && mode60, "R5 lock 60", int'({locked, mode60}), 3);

    // R7/R8: out-of-window sync ignored, flywheel at window end
    runField(250, fl);
    chk(fl == 264, "R7/R8 flywheel length", fl, 264);
    chk(locked, "R8 stays locked", int'(locked), 1);
    repeat (4) runField(-1, fl);
    chk(fl == 264 && locked, "R8 flywheel run", fl, 264);
    runField(262, fl);
    chk(fl == 262, "R7 accepted in window", fl, 262);
    // R9: run cleared by the accepted sync
    repeat (5) runField(-1, fl);
    chk(locked, "R9 five misses keep lock", int'(locked), 1);
    runField(-1, fl);
    chk(!locked && fl == 264, "R9 six misses unlock", int'(locked), 0);
    exp = 262 + (fields % 2);
    runField(-1, fl);
    chk(fl == exp && mode60, "R4 free length 60", fl, exp);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule